// File: doc/BRIEF.md
# Programmable Serial Test Pattern Generator

This block produces a serial test bit stream for line and framer testing, one bit for each cycle in which its bit-enable input is high. A framer or payload mapper drives that enable. It decides which slots carry test data, so channel selection and framing stay outside this block. The stream is either a fixed word of programmable length that repeats, or a pseudo-random sequence. The sequence comes from a shift register whose length and feedback tap are set at runtime. The same 32-bit word acts as the repeat pattern in one mode and as the shift-register seed in the other.

The configuration (mode, word, length, tap, error-rate code) is captured on a write strobe. The new sequence starts from its first bit on the next enabled bit. Deliberate bit errors can be inserted, either one at a time on request or continuously at a rate of one per 10^n bits. The whole stream can be complemented with a live invert control. The output is registered and has a valid flag that marks each new bit.

Top module: `pattern_bitgen`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `bit_valid` and `bit_out` are 0. Reset clears the captured configuration to: repeat mode, word 0, length field 0, tap 0, rate code 0. It also arms a reload.
- R2: `bit_valid` is high exactly in the cycle after a cycle with `bit_en` high. In that cycle `bit_out` carries the new bit. With `bit_en` low, `bit_out` keeps its value.
- R3: In repeat mode (`prbs_sel`=0) with length field L, the bits are sent most significant first: word[L], word[L-1] … word[0], and then the run repeats every L+1 bits. A length field of 0 acts as 1.
- R4: In pseudo-random mode (`prbs_sel`=1), the state starts as word[L:0], and an all-zero start is replaced by all ones. Each bit sends state stage L. The state then shifts one place toward stage L, and stage 0 takes stage L XOR stage T (T = tap field). If T ≥ L, stage 0 takes stage L alone.
- R5: A high `err_single` inverts the first enabled bit in the same cycle or any later cycle, exactly once. Several requests before that bit merge into one inversion.
- R6: Rate code n in 1..7 inverts every 10^n-th enabled bit, counted from the last configuration write. Code 0 inserts no errors. A bit picked by both the rate and a single request is inverted once.
- R7: `inv_out` high, sampled with the enabled bit, complements that bit after error insertion.
- R8: `cfg_wr` captures all configuration inputs. An enabled bit in the same cycle still uses the old state and settings. The next enabled bit is the first bit of the new sequence, and the rate count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Produce one bit this cycle |
| cfg_wr | input | 1 | Capture configuration, reload sequence |
| prbs_sel | input | 1 | 0 repeat word, 1 pseudo-random |
| pat_word | input | 32 | Repeat word or seed |
| len_sel | input | 5 | Highest valid bit index L |
| tap_sel | input | 5 | Feedback tap position T |
| rate_sel | input | 3 | Continuous error-rate code |
| err_single | input | 1 | Request one inverted bit |
| inv_out | input | 1 | Complement output |
| bit_out | output | 1 | Serial test bit |
| bit_valid | output | 1 | New bit present on bit_out |

## Verification
The bench captures a 6-bit-field pseudo-random run with tap 5 and checks that it repeats after 127 bits with 64 ones. A wrong shift direction or tap placement breaks that period. An all-zero seed must still give ones rather than a stuck stream. A configuration write in the same cycle as an enabled bit must leave that bit on the old pattern: a design that reloads too early would drop the old bit. An error request made while the enable is low must survive until the next enabled bit. Rate code 1 must put an inverted bit at every tenth bit of a zero stream. An off-by-one counter would shift every one of those marks.

// File: rtl/bpg_pkg.sv
package bpg_pkg;
  localparam int PAT_W  = 32;
  localparam int LEN_W  = $clog2(PAT_W);
  localparam int RATE_W = 3;
  localparam int CNT_W  = 24;

  typedef struct packed {
    logic              prbs;
    logic [PAT_W-1:0]  pat;
    logic [LEN_W-1:0]  len;
    logic [LEN_W-1:0]  tap;
    logic [RATE_W-1:0] rate;
  } bpg_cfg_t;

  // 10^n, n = 0 gives 1
  function automatic logic [CNT_W-1:0] pow10(input logic [RATE_W-1:0] n);
    logic [CNT_W-1:0] v;
    v = CNT_W'(1);
    for (int i = 1; i < (1 << RATE_W); i++)
      if (i <= int'(n)) v = v * CNT_W'(10);
    return v;
  endfunction
endpackage

// File: rtl/bpg_cfg.sv
module bpg_cfg
  import bpg_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     cfg_wr,
  input  logic     bit_en,
  input  bpg_cfg_t cfg_in,
  output bpg_cfg_t cfg_q,
  output logic     load_pend
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= '0;
      load_pend <= 1'b1;
    end else begin
      if (cfg_wr) cfg_q <= cfg_in;
      if (cfg_wr)      load_pend <= 1'b1;
      else if (bit_en) load_pend <= 1'b0;
    end
  end

  // R8: a write always arms a reload for the next enabled bit
  a_r8_reload_armed: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> load_pend);
endmodule

// File: rtl/bpg_shift.sv
module bpg_shift
  import bpg_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     bit_en,
  input  logic     load,
  input  bpg_cfg_t cfg,
  output logic     stage_bit
);
  logic [PAT_W-1:0] sr, mask, seed, cur, nxt;
  logic [LEN_W-1:0] eff_len;
  logic             fb;

  always_comb begin
    eff_len = (cfg.len == '0) ? LEN_W'(1) : cfg.len;
    for (int i = 0; i < PAT_W; i++)
      mask[i] = (i <= int'(eff_len));
    seed = cfg.pat & mask;
    if (cfg.prbs && seed == '0) seed = mask;
    cur       = load ? seed : sr;
    stage_bit = cur[eff_len];
    fb        = cur[eff_len];
    if (cfg.prbs && (cfg.tap < eff_len)) fb = fb ^ cur[cfg.tap];
    nxt = ((cur << 1) | {{(PAT_W-1){1'b0}}, fb}) & mask;
  end

  always_ff @(posedge clk) begin
    if (rst)         sr <= '0;
    else if (bit_en) sr <= nxt;
  end

  // R4: pseudo-random state never locks up at zero
  a_r4_no_lockup: assert property (@(posedge clk) disable iff (rst)
    (cfg.prbs && !load) |-> (sr != '0));
  // R3: bits above the programmed length stay clear
  a_r3_len_bound: assert property (@(posedge clk) disable iff (rst)
    !load |-> ((sr & ~mask) == '0));
endmodule

// File: rtl/bpg_err.sv
module bpg_err
  import bpg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              cfg_wr,
  input  logic [RATE_W-1:0] rate,
  input  logic              err_single,
  output logic              flip
);
  logic [CNT_W-1:0] cnt, limit;
  logic             pend, rate_hit;

  always_comb begin
    limit    = pow10(rate) - CNT_W'(1);
    rate_hit = (rate != '0) && (cnt == limit);
    flip     = rate_hit | pend | err_single;
  end

  always_ff @(posedge clk) begin
    if (rst)               pend <= 1'b0;
    else if (bit_en)       pend <= 1'b0;
    else if (err_single)   pend <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || cfg_wr)
      cnt <= '0;
    else if (bit_en && rate != '0)
      cnt <= rate_hit ? '0 : cnt + 1'b1;
  end

  // R6: the bit counter never runs past its interval
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    (rate != '0) |-> (cnt <= limit));
  // R5: a consumed single request does not linger
  a_r5_single_once: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !err_single) |=> !pend);
endmodule

// File: rtl/pattern_bitgen.sv
module pattern_bitgen
  import bpg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              cfg_wr,
  input  logic              prbs_sel,
  input  logic [PAT_W-1:0]  pat_word,
  input  logic [LEN_W-1:0]  len_sel,
  input  logic [LEN_W-1:0]  tap_sel,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              err_single,
  input  logic              inv_out,
  output logic              bit_out,
  output logic              bit_valid
);
  bpg_cfg_t cfg_in, cfg_q;
  logic     load_pend, stage_bit, flip;

  always_comb begin
    cfg_in.prbs = prbs_sel;
    cfg_in.pat  = pat_word;
    cfg_in.len  = len_sel;
    cfg_in.tap  = tap_sel;
    cfg_in.rate = rate_sel;
  end

  bpg_cfg u_cfg (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .bit_en(bit_en),
    .cfg_in(cfg_in), .cfg_q(cfg_q), .load_pend(load_pend)
  );

  bpg_shift u_shift (
    .clk(clk), .rst(rst), .bit_en(bit_en), .load(load_pend),
    .cfg(cfg_q), .stage_bit(stage_bit)
  );

  bpg_err u_err (
    .clk(clk), .rst(rst), .bit_en(bit_en), .cfg_wr(cfg_wr),
    .rate(cfg_q.rate), .err_single(err_single), .flip(flip)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_out   <= 1'b0;
      bit_valid <= 1'b0;
    end else begin
      bit_valid <= bit_en;
      if (bit_en) bit_out <= stage_bit ^ flip ^ inv_out;
    end
  end

  // R2: output holds between enabled bits
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(bit_out));
  // R1: nothing is flagged valid right after reset
  a_r1_quiet: assert property (@(posedge clk)
    rst |=> !bit_valid);
endmodule

// File: tb/pattern_bitgen_test.sv
module pattern_bitgen_test;
  import bpg_pkg::*;

  logic clk = 1'b0, rst = 1'b1;
  logic bit_en = 0, cfg_wr = 0, prbs_sel = 0, err_single = 0, inv_out = 0;
  logic [PAT_W-1:0]  pat_word = '0;
  logic [LEN_W-1:0]  len_sel = '0, tap_sel = '0;
  logic [RATE_W-1:0] rate_sel = '0;
  logic bit_out, bit_valid;

  always #10 clk = ~clk;

  pattern_bitgen uut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .cfg_wr(cfg_wr), .prbs_sel(prbs_sel),
    .pat_word(pat_word), .len_sel(len_sel), .tap_sel(tap_sel), .rate_sel(rate_sel),
    .err_single(err_single), .inv_out(inv_out), .bit_out(bit_out), .bit_valid(bit_valid)
  );

  int vectors = 0, miscompares = 0;
  bit done = 0;
  string req = "R1";

  // reference state, derived from the requirements
  logic              m_prbs, m_load, m_pend, exp_out, exp_valid;
  logic [PAT_W-1:0]  m_pat, m_sr;
  logic [LEN_W-1:0]  m_len, m_tap;
  logic [RATE_W-1:0] m_rate;
  int                m_cnt;

  logic cap [0:1023];
  int   cap_n = 0;

  function automatic int p10(input int n);
    int v = 1;
    for (int i = 0; i < n; i++) v = v * 10;
    return v;
  endfunction

  task automatic model_reset();
    m_prbs = 0; m_pat = '0; m_len = '0; m_tap = '0; m_rate = '0;
    m_load = 1; m_pend = 0; m_cnt = 0; m_sr = '0;
    exp_out = 0; exp_valid = 0;
  endtask

  task automatic model(input logic en, input logic wr, input logic sing, input logic inv);
    int L;
    logic [PAT_W-1:0] msk, sd, cur;
    logic b, fb, hit;
    L = (m_len == 0) ? 1 : int'(m_len);
    msk = '0;
    for (int i = 0; i <= L; i++) msk[i] = 1'b1;
    sd = m_pat & msk;
    if (m_prbs && sd == '0) sd = msk;
    cur = m_load ? sd : m_sr;
    b = cur[L];
    hit = (m_rate != 0) && (m_cnt == p10(int'(m_rate)) - 1);
    exp_valid = en;
    if (en) begin
      exp_out = b ^ (hit | m_pend | sing) ^ inv;
      fb = cur[L];
      if (m_prbs && int'(m_tap) < L) fb = fb ^ cur[m_tap];
      m_sr = ((cur << 1) | PAT_W'(fb)) & msk;
    end
    if (wr) m_cnt = 0;
    else if (en && m_rate != 0) m_cnt = hit ? 0 : m_cnt + 1;
    m_pend = en ? 1'b0 : (sing ? 1'b1 : m_pend);
    m_load = wr ? 1'b1 : (en ? 1'b0 : m_load);
    if (wr) begin
      m_prbs = prbs_sel; m_pat = pat_word; m_len = len_sel;
      m_tap = tap_sel; m_rate = rate_sel;
    end
  endtask

  task automatic check(input string r, input logic got, input logic exp, input string what);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %0b expected %0b", r, what, got, exp);
    end
  endtask

  task automatic step(input logic en, input logic wr, input logic sing, input logic inv);
    @(negedge clk);
    bit_en = en; cfg_wr = wr; err_single = sing; inv_out = inv;
    model(en, wr, sing, inv);
    @(posedge clk); #2;
    check(req, bit_valid, exp_valid, "bit_valid");
    check(req, bit_out, exp_out, "bit_out");
    if (bit_valid && cap_n < 1024) begin cap[cap_n] = bit_out; cap_n++; end
  endtask

  task automatic setcfg(input logic p, input logic [PAT_W-1:0] w, input int l,
                        input int t, input int r);
    prbs_sel = p; pat_word = w; len_sel = LEN_W'(l); tap_sel = LEN_W'(t);
    rate_sel = RATE_W'(r);
    step(0, 1, 0, 0);
    cap_n = 0;
  endtask

  initial begin
    int ones;
    void'($urandom(32'd2718));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    @(posedge clk); #2;
    req = "R1";
    check("R1", bit_valid, 1'b0, "valid after reset");
    check("R1", bit_out, 1'b0, "out after reset");
    step(1, 0, 0, 0);  // default config: repeat word 0 -> zero bit

    // R3: repeat word 1010, L=3, MSB first
    req = "R3";
    setcfg(0, 32'hFFFF_FFFA, 3, 0, 0);
    for (int i = 0; i < 12; i++) step(1, 0, 0, 0);
    for (int i = 0; i < 12; i++)
      check("R3", cap[i], (i % 2 == 0), "repeat bit order");
    // R3: L=0 acts as 1
    setcfg(0, 32'h2, 0, 0, 0);
    for (int i = 0; i < 6; i++) step(1, 0, 0, 0);
    check("R3", cap[0], 1'b1, "len0 first bit");
    check("R3", cap[1], 1'b0, "len0 second bit");
    check("R3", cap[2], 1'b1, "len0 period 2");

    // R2: gaps in enable hold output
    req = "R2";
    for (int i = 0; i < 20; i++) step(i % 3 == 0, 0, 0, 0);

    // R4: maximal 7-stage sequence, period 127
    req = "R4";
    setcfg(1, 32'h1, 6, 5, 0);
    for (int i = 0; i < 254; i++) step(1, 0, 0, 0);
    ones = 0;
    for (int i = 0; i < 127; i++) begin
      ones += int'(cap[i]);
      if (cap[i] !== cap[i+127]) check("R4", cap[i+127], cap[i], "period 127");
    end
    check("R4", ones == 64, 1'b1, "64 ones per period");
    // R4: zero seed becomes all ones
    setcfg(1, 32'h0, 4, 2, 0);
    for (int i = 0; i < 10; i++) step(1, 0, 0, 0);
    for (int i = 0; i < 5; i++) check("R4", cap[i], 1'b1, "zero seed replaced");

    // R5: request while idle lands on next enabled bit, once
    req = "R5";
    setcfg(0, 32'h0, 7, 0, 0);
    step(0, 0, 1, 0);
    step(0, 0, 1, 0);
    step(0, 0, 0, 0);
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0);
    check("R5", cap[0], 1'b1, "single error applied");
    check("R5", cap[1], 1'b0, "single error once");

    // R6: code 1 -> every 10th bit
    req = "R6";
    setcfg(0, 32'h0, 7, 0, 1);
    for (int i = 0; i < 40; i++) step(1, 0, 0, 0);
    for (int i = 0; i < 40; i++)
      check("R6", cap[i], (i % 10 == 9), "rate 1 position");

    // R7: invert
    req = "R7";
    setcfg(0, 32'h0, 7, 0, 0);
    for (int i = 0; i < 8; i++) step(1, 0, 0, 1);
    check("R7", cap[3], 1'b1, "inverted zero");

    // R8: write with enable in same cycle keeps old bit
    req = "R8";
    setcfg(0, 32'hFF, 7, 0, 0);
    step(1, 0, 0, 0);
    pat_word = 32'h0;
    step(1, 1, 0, 0);
    step(1, 0, 0, 0);
    check("R8", cap[1], 1'b1, "old bit on write cycle");
    check("R8", cap[2], 1'b0, "new sequence after write");

    // random mix
    for (int k = 0; k < 40; k++) begin
      int n;
      logic iv;
      req = (k % 2) ? "R4" : "R3";
      iv = 0;
      setcfg($urandom % 2, $urandom, $urandom % 32, $urandom % 32,
             (k % 9 == 8) ? 7 : $urandom % 4);
      n = 200 + $urandom % 600;
      for (int i = 0; i < n; i++) begin
        if ($urandom % 100 == 0) iv = ~iv;
        if ($urandom % 150 == 0) begin
          req = "R8";
          pat_word = $urandom; len_sel = LEN_W'($urandom);
          step($urandom % 2, 1, 0, iv);
        end else
          step(($urandom % 10) < 7, 0, ($urandom % 50) == 0, iv);
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog %s: got timeout expected completion", req);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule